// File: doc/BRIEF.md
# Registered-Read Show-Ahead Synchronous FIFO

This block is a single-clock FIFO. Its storage array has a clocked read port, so it maps onto an inferred block RAM. On the read side it behaves as first-word-fall-through. Whenever `empty` is low, `rd_data` already holds the oldest stored word, and asserting `rd_en` consumes that word. There is no request-then-wait step.

The clocked RAM read adds one cycle of latency. The block hides it in two ways. First, the RAM is always addressed with the head pointer as it will be after the current edge. Second, a one-entry bypass register catches a word that is written in the same cycle the FIFO runs dry, or while it is already empty, and shows that word at the output.

Occupancy is held in a registered counter. The status outputs are registered state that describes the FIFO after the transfers accepted on each edge. They are not combinational comparisons of the two pointers. Both pointers carry one wrap bit above the address bits. Depth must be a power of two.

Top module: `bram_fwft_fifo`

## Requirements
- R1: While reset is held and immediately after it is released, `empty` is 1 and `full` is 0, and the FIFO holds no word.
- R2: A word written while the FIFO is empty is presented on `rd_data` with `empty` low right after that clock edge, with no idle cycle in between.
- R3: Words leave in exactly the order in which they were accepted, under any mix of reads and writes, including across pointer wrap-around. While `empty` is low, `rd_data` equals the oldest unread word.
- R4: After DEPTH accepted writes with no reads, `full` is 1. A write while `full` is 1 and `rd_en` is 0 is discarded: it changes neither the flags nor the stored contents.
- R5: A read while `empty` is 1 is ignored. The flags stay unchanged, and the next word written is the next word read.
- R6: A read of the last stored word with no write in the same cycle sets `empty` on that same edge. The flag reflects the occupancy after the read.
- R7: When the FIFO holds between 1 and DEPTH-1 words, a simultaneous read and write leaves `empty` and `full` unchanged. With one word stored, the newly written word becomes `rd_data` on the next cycle.
- R8: When the FIFO is full, a simultaneous read and write accepts only the read. `full` drops, and the offered write word never appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request; accepted when `full` is 0 |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Registered: FIFO holds DEPTH words |
| rd_en | input | 1 | Read request; accepted when `empty` is 0 |
| rd_data | output | DATA_W | Oldest stored word, valid while `empty` is 0 |
| empty | output | 1 | Registered: FIFO holds no word |

## Verification
An error in the occupancy counter or the empty register shows up within one edge as a flag that disagrees with the number of words actually written and read. Examples are a late `empty` after the last read, or `full` rising one word early or late. A wrong RAM read address, or a bypass that fails to fire, shows up as a stale or repeated `rd_data` in the cycle right after the edge concerned. This is most visible after a write into an empty FIFO and during streaming with one word stored. A write that slips through while full, or a read that slips through while empty, corrupts the ordering that the drain sequence later exposes.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Transfer accepted on an edge, {write, read}
  typedef enum logic [1:0] {
    XFER_NONE = 2'b00,
    XFER_POP  = 2'b01,
    XFER_PUSH = 2'b10,
    XFER_BOTH = 2'b11
  } xfer_e;
endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr_nxt,
  output logic          full,
  output logic          empty
);

  if ((DEPTH < 2) || ((1 << AW) != DEPTH)) begin : g_bad_depth
    $error("fifo_ctrl: DEPTH must be a power of two and at least 2");
  end

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          empty_q, empty_d;
  xfer_e         xfer;

  assign full   = cnt_q[AW];
  assign empty  = empty_q;
  assign wr_acc = wr_en & ~full;
  assign rd_acc = rd_en & ~empty_q;
  assign xfer   = xfer_e'({wr_acc, rd_acc});

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    empty_d  = empty_q;
    case (xfer)
      XFER_PUSH: begin
        wr_ptr_d = wr_ptr_q + PW'(1);
        cnt_d    = cnt_q + PW'(1);
        empty_d  = 1'b0;
      end
      XFER_POP: begin
        rd_ptr_d = rd_ptr_q + PW'(1);
        cnt_d    = cnt_q - PW'(1);
        empty_d  = (cnt_q <= PW'(1));
      end
      XFER_BOTH: begin
        wr_ptr_d = wr_ptr_q + PW'(1);
        rd_ptr_d = rd_ptr_q + PW'(1);
      end
      default: ;
    endcase
  end

  assign waddr     = wr_ptr_q[AW-1:0];
  assign raddr_nxt = rd_ptr_d[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      empty_q  <= 1'b1;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      empty_q  <= empty_d;
    end
  end

  AST_PTR_SPAN: assert property (@(posedge clk) disable iff (!rst_n) (wr_ptr_q - rd_ptr_q) == cnt_q); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (full && wr_en && !rd_en) |=> ($stable(wr_ptr_q) && full)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (empty && rd_en && !wr_en) |=> ($stable(rd_ptr_q) && empty)); // R5
  AST_EMPTY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) empty_q == (cnt_q == '0)); // R6
  AST_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !wr_en && !empty && cnt_q == PW'(1)) |=> empty); // R6
  AST_BOTH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (wr_acc && rd_acc) |=> ($stable(cnt_q) && $stable(empty_q))); // R7
  AST_FULL_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (full && wr_en && rd_en) |=> (!full && $stable(wr_ptr_q))); // R8

endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Clocked read: rdata follows raddr one edge later (read-before-write)
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fifo_head.sv
module fifo_head #(
  parameter int DATA_W = 32,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic [AW-1:0]     waddr,
  input  logic [AW-1:0]     raddr_nxt,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] ram_q,
  output logic [DATA_W-1:0] rd_data
);

  logic              byp_sel_q, byp_sel_d;
  logic [DATA_W-1:0] byp_data_q;

  // The word written this edge becomes the head only when the FIFO is
  // left empty by this edge's read (or was empty): RAM would return stale data.
  assign byp_sel_d = wr_acc && (waddr == raddr_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_sel_q <= 1'b0;
    end else begin
      byp_sel_q <= byp_sel_d;
    end
  end

  always_ff @(posedge clk) begin
    if (byp_sel_d) begin
      byp_data_q <= wr_data;
    end
  end

  assign rd_data = byp_sel_q ? byp_data_q : ram_q;

  AST_BYPASS_SHOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n) byp_sel_d |=> (rd_data == $past(wr_data))); // R2

endmodule

// File: rtl/bram_fwft_fifo.sv
module bram_fwft_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);

  logic              wr_acc;
  logic              rd_acc;
  logic [AW-1:0]     waddr;
  logic [AW-1:0]     raddr_nxt;
  logic [DATA_W-1:0] ram_q;

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_acc    (wr_acc),
    .rd_acc    (rd_acc),
    .waddr     (waddr),
    .raddr_nxt (raddr_nxt),
    .full      (full),
    .empty     (empty)
  );

  fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_acc),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr_nxt),
    .rdata (ram_q)
  );

  fifo_head #(.DATA_W(DATA_W), .AW(AW)) u_head (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_acc    (wr_acc),
    .waddr     (waddr),
    .raddr_nxt (raddr_nxt),
    .wr_data   (wr_data),
    .ram_q     (ram_q),
    .rd_data   (rd_data)
  );

  AST_NEVER_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R1
  AST_READ_NOT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (rd_acc |-> !empty)); // R5

endmodule

// File: tb/sim_bram_fwft_fifo.sv
`timescale 1ns/1ps
module sim_bram_fwft_fifo;
  localparam int DW = 16;
  localparam int DEP = 8;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          full;
  logic          rd_en;
  logic [DW-1:0] rd_data;
  logic          empty;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [$];
  logic [15:0] lfsr = 16'hACE1;

  bram_fwft_fifo #(.DATA_W(DW), .DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model, sample 1 ns after the edge
  task automatic cyc(input logic we, input logic [DW-1:0] wd, input logic re, input string tag);
    bit wacc, racc;
    @(negedge clk);
    wr_en = we; wr_data = wd; rd_en = re;
    wacc = we && (model.size() < DEP);
    racc = re && (model.size() > 0);
    @(posedge clk);
    if (racc) void'(model.pop_front());
    if (wacc) model.push_back(wd);
    #1;
    chk(empty == (model.size() == 0), tag, "empty", 32'(empty), 32'(model.size() == 0));
    chk(full == (model.size() == DEP), tag, "full", 32'(full), 32'(model.size() == DEP));
    if (model.size() > 0)
      chk(rd_data == model[0], tag, "rd_data", 32'(rd_data), 32'(model[0]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(empty == 1'b1, "R1", "empty in reset", 32'(empty), 1);
    chk(full == 1'b0, "R1", "full in reset", 32'(full), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(empty == 1'b1 && full == 1'b0, "R1", "flags after release", {30'b0, full, empty}, 1);
    cyc(1'b0, '0, 1'b0, "R1");
  endtask

  task automatic t_fwft();
    cyc(1'b1, 16'hBEEF, 1'b0, "R2");
    chk(!empty && rd_data == 16'hBEEF, "R2", "word visible at once", 32'(rd_data), 32'hBEEF);
    cyc(1'b0, '0, 1'b1, "R6");
    chk(empty == 1'b1, "R6", "empty after last read", 32'(empty), 1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEP; i++) cyc(1'b1, 16'h1000 + 16'(i), 1'b0, "R4");
    chk(full == 1'b1, "R4", "full after DEPTH writes", 32'(full), 1);
    cyc(1'b1, 16'hDEAD, 1'b0, "R4");
    cyc(1'b1, 16'hDEAD, 1'b0, "R4");
    for (int i = 0; i < DEP; i++) begin
      chk(rd_data == 16'h1000 + 16'(i), "R3", "drain order", 32'(rd_data), 32'h1000 + i);
      cyc(1'b0, '0, 1'b1, "R3");
    end
    chk(empty == 1'b1, "R4", "discarded write not stored", 32'(empty), 1);
  endtask

  task automatic t_underflow();
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, "R5");
    chk(empty == 1'b1 && full == 1'b0, "R5", "flags after empty reads", {30'b0, full, empty}, 1);
    cyc(1'b1, 16'h5A5A, 1'b0, "R5");
    chk(rd_data == 16'h5A5A, "R5", "next write is next read", 32'(rd_data), 32'h5A5A);
    cyc(1'b0, '0, 1'b1, "R5");
  endtask

  task automatic t_both();
    cyc(1'b1, 16'h2000, 1'b0, "R7");
    for (int i = 1; i < 6; i++) begin
      cyc(1'b1, 16'h2000 + 16'(i), 1'b1, "R7");
      chk(!empty && rd_data == 16'h2000 + 16'(i), "R7", "stream with one word", 32'(rd_data), 32'h2000 + i);
    end
    cyc(1'b1, 16'h2100, 1'b0, "R7");
    cyc(1'b1, 16'h2101, 1'b0, "R7");
    for (int i = 0; i < 4; i++) cyc(1'b1, 16'h2200 + 16'(i), 1'b1, "R7");
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, "R7");
    chk(empty == 1'b1, "R7", "empty after drain", 32'(empty), 1);
  endtask

  task automatic t_full_both();
    for (int i = 0; i < DEP; i++) cyc(1'b1, 16'h3000 + 16'(i), 1'b0, "R8");
    cyc(1'b1, 16'hF00D, 1'b1, "R8");
    chk(full == 1'b0 && !empty, "R8", "full drops on read", 32'(full), 0);
    for (int i = 1; i < DEP; i++) begin
      chk(rd_data != 16'hF00D, "R8", "offered word absent", 32'(rd_data), 32'h3000 + i);
      cyc(1'b0, '0, 1'b1, "R8");
    end
    chk(empty == 1'b1, "R8", "only DEPTH-1 words remained", 32'(empty), 1);
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i < 200) cyc(lfsr[0] | lfsr[1], lfsr ^ 16'(i), lfsr[2], "R3");
      else         cyc(lfsr[3], lfsr ^ 16'(i), lfsr[0] | lfsr[1], "R3");
    end
    while (model.size() > 0) cyc(1'b0, '0, 1'b1, "R3");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fwft();
    t_fill();
    t_underflow();
    t_both();
    t_full_both();
    t_mixed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule